// File: doc/BRIEF.md
# Virtual-Channel Router Input Pipeline

This block is the input side of one port of a wormhole router that shares a physical link among several virtual channels (VCs). Flits arrive one per cycle, each tagged with the VC it travels on and with its kind: head, body or tail. Every VC has its own flit FIFO and a small state machine. A packet's head flit goes through route computation and then VC allocation. After that, the head and every later flit of the packet compete for the switch and cross it into a registered output stage. That stage carries the flit, its output direction and the output VC granted to the packet.

Routes are computed in dimension order on a 2-D mesh. A packet first travels along X until its destination column matches the router's own column, and only then along Y. The VC allocator and the switch allocator sit outside the block. The block raises one request to each allocator per cycle and receives a grant back in the same cycle. Body and tail flits never touch routing or VC allocation: they inherit both from their head and wait behind it in their FIFO. A tail flit that crosses the switch frees its VC for the next packet.

Top module: `vc_input_pipe`

## Requirements
- R1: During and right after synchronous reset, `out_valid`, `va_req` and `sa_req` are low.
- R2: Flit kinds are encoded as 0 = body, 1 = head, 2 = tail. A head flit carries the destination X in `in_data[COORD_W-1:0]` and the destination Y in `in_data[2*COORD_W-1:COORD_W]`. The direction is east (1) if the destination X is above the router's X and west (2) if it is below. When the X values are equal, the direction is north (3) if the destination Y is above the router's Y and south (4) if it is below. When both coordinates match, the direction is local (0). The direction appears on `va_req_port`, `sa_req_port` and `out_port`.
- R3: Only a VC whose oldest buffered flit is a head flit raises `va_req`. Body and tail flits never cause a VC request.
- R4: With every grant given at once, a head flit presented in cycle 0 appears on the output in cycle 4. Each following flit of the packet, presented one per cycle, appears one cycle after the flit before it.
- R5: A flit whose switch request is not granted asks again in the next cycle. It and every later flit of its packet leave one cycle later per denied cycle.
- R6: Within one VC, flits leave in arrival order with unchanged data and kind. Each flit is tagged with its packet's direction and with the output VC granted to that packet.
- R7: Once a tail flit crosses the switch, the VC is free again. The next packet on that VC must pass route computation and a new VC grant, and none of its flits requests the switch before that grant.
- R8: Flits that arrive while their head is still in route computation or VC allocation are held in the VC's FIFO, up to `FIFO_DEPTH` flits, and none is lost.
- R9: Switch requests rotate among ready VCs. A VC is ready when it holds a VC grant and has a buffered flit. After VC v is granted, the next request goes to the first ready VC after v in ascending cyclic order.
- R10: A flit granted the switch in cycle k appears on the output in cycle k+1. `out_valid` is low in every cycle that follows a cycle without a switch grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | VC_W | VC of the incoming flit |
| in_kind | input | 2 | Incoming flit kind (0 body, 1 head, 2 tail) |
| in_data | input | DATA_W | Incoming flit payload (head: destination coordinates in low bits) |
| va_req | output | 1 | VC allocation request |
| va_req_vc | output | VC_W | Input VC asking for an output VC |
| va_req_port | output | 3 | Direction the requesting packet needs |
| va_grant | input | 1 | VC allocation granted this cycle |
| va_grant_ovc | input | VC_W | Output VC given with the grant |
| sa_req | output | 1 | Switch allocation request |
| sa_req_vc | output | VC_W | Input VC asking for the switch |
| sa_req_port | output | 3 | Direction of the requesting flit |
| sa_grant | input | 1 | Switch granted this cycle |
| out_valid | output | 1 | Flit on the output stage |
| out_port | output | 3 | Direction of the output flit |
| out_vc | output | VC_W | Output VC of the output flit |
| out_kind | output | 2 | Kind of the output flit |
| out_data | output | DATA_W | Payload of the output flit |

## Verification
A VC stuck in the wrong state shows up on the allocator requests within a cycle or two. A VC that was not released never raises `va_req` for its next head. A VC that was released early puts a flit on `sa_req` before its VC grant. A corrupted FIFO pointer or a wrong rotation pointer shows on the very next switch grant, as the wrong flit, kind or direction on the output one cycle later. The bench therefore checks every request and every output cycle against its own model of the per-VC queues, VC ownership and rotation order, so a fault is reported within one or two cycles of its cause.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

  typedef enum logic [1:0] {
    FL_BODY = 2'd0,
    FL_HEAD = 2'd1,
    FL_TAIL = 2'd2
  } flit_kind_e;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_WEST  = 3'd2,
    DIR_NORTH = 3'd3,
    DIR_SOUTH = 3'd4
  } dir_e;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_ROUTE  = 2'd1,
    VS_WAITVC = 2'd2,
    VS_ACTIVE = 2'd3
  } vc_state_e;

endpackage

// File: rtl/vcr_flit_fifo.sv
module vcr_flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

endmodule

// File: rtl/vcr_dor_route.sv
module vcr_dor_route
  import vcr_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output logic [2:0]         dir
);
  localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

  // X is resolved completely before Y is looked at
  always_comb begin
    if (dest_x > OWN_X)      dir = DIR_EAST;
    else if (dest_x < OWN_X) dir = DIR_WEST;
    else if (dest_y > OWN_Y) dir = DIR_NORTH;
    else if (dest_y < OWN_Y) dir = DIR_SOUTH;
    else                     dir = DIR_LOCAL;
  end

endmodule

// File: rtl/vcr_rr_pick.sv
module vcr_rr_pick #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic                 pick_valid,
  output logic [$clog2(N)-1:0] pick_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;

  always_comb begin
    int cand;
    pick_valid = 1'b0;
    pick_idx   = last;
    for (int off = 1; off <= N; off++) begin
      cand = (int'(last) + off) % N;
      if (!pick_valid && req[cand]) begin
        pick_valid = 1'b1;
        pick_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          last <= IW'(N - 1);
    else if (advance) last <= pick_idx;
  end

  // R9
  pick_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> req[pick_idx]);

endmodule

// File: rtl/vc_input_pipe.sv
module vc_input_pipe
  import vcr_pkg::*;
#(
  parameter int NUM_VC     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 3,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [$clog2(NUM_VC)-1:0] in_vc,
  input  logic [1:0]                in_kind,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      va_req,
  output logic [$clog2(NUM_VC)-1:0] va_req_vc,
  output logic [2:0]                va_req_port,
  input  logic                      va_grant,
  input  logic [$clog2(NUM_VC)-1:0] va_grant_ovc,
  output logic                      sa_req,
  output logic [$clog2(NUM_VC)-1:0] sa_req_vc,
  output logic [2:0]                sa_req_port,
  input  logic                      sa_grant,
  output logic                      out_valid,
  output logic [2:0]                out_port,
  output logic [$clog2(NUM_VC)-1:0] out_vc,
  output logic [1:0]                out_kind,
  output logic [DATA_W-1:0]         out_data
);
  localparam int VC_W = $clog2(NUM_VC);
  localparam int FW   = DATA_W + 2;

  vc_state_e         vc_state [NUM_VC];
  logic [2:0]        vc_port  [NUM_VC];
  logic [VC_W-1:0]   vc_ovc   [NUM_VC];
  logic [FW-1:0]     front    [NUM_VC];
  logic [2:0]        route_dir[NUM_VC];
  logic [NUM_VC-1:0] wr_vec, rd_vec, empty_vec, full_vec, wait_vec, ready_vec;
  logic              va_fire, sa_fire;

  assign va_fire = va_req && va_grant;
  assign sa_fire = sa_req && sa_grant;

  // per-VC buffer, route unit and state machine
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign wr_vec[v] = in_valid && (in_vc == VC_W'(v));
    assign rd_vec[v] = sa_fire && (sa_req_vc == VC_W'(v));

    vcr_flit_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_vec[v]),
      .wr_data ({in_kind, in_data}),
      .rd_en   (rd_vec[v]),
      .rd_data (front[v]),
      .empty   (empty_vec[v]),
      .full    (full_vec[v])
    );

    vcr_dor_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dest_x (front[v][COORD_W-1:0]),
      .dest_y (front[v][2*COORD_W-1:COORD_W]),
      .dir    (route_dir[v])
    );

    assign wait_vec[v]  = (vc_state[v] == VS_WAITVC);
    assign ready_vec[v] = (vc_state[v] == VS_ACTIVE) && !empty_vec[v];

    always_ff @(posedge clk) begin
      if (rst) begin
        vc_state[v] <= VS_IDLE;
        vc_port[v]  <= DIR_LOCAL;
        vc_ovc[v]   <= '0;
      end else begin
        case (vc_state[v])
          VS_IDLE: begin
            if (!empty_vec[v] || wr_vec[v]) vc_state[v] <= VS_ROUTE;
          end
          VS_ROUTE: begin
            vc_port[v]  <= route_dir[v];
            vc_state[v] <= VS_WAITVC;
          end
          VS_WAITVC: begin
            if (va_fire && (va_req_vc == VC_W'(v))) begin
              vc_ovc[v]   <= va_grant_ovc;
              vc_state[v] <= VS_ACTIVE;
            end
          end
          default: begin
            if (rd_vec[v] && (front[v][FW-1:DATA_W] == FL_TAIL))
              vc_state[v] <= VS_IDLE;
          end
        endcase
      end
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ready_vec[v] && !rd_vec[v]) |=> ready_vec[v]);

    // R7
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_vec[v] && (front[v][FW-1:DATA_W] == FL_TAIL)) |=> (vc_state[v] != VS_ACTIVE));

    // R2
    route_range_chk: assert property (@(posedge clk) disable iff (rst)
      (vc_state[v] == VS_ROUTE) |-> (route_dir[v] <= DIR_SOUTH));
  end

  // VC allocation request: lowest waiting VC first
  always_comb begin
    va_req    = 1'b0;
    va_req_vc = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (wait_vec[i]) begin
        va_req    = 1'b1;
        va_req_vc = VC_W'(i);
      end
    end
  end
  assign va_req_port = vc_port[va_req_vc];

  // switch allocation request: rotating among ready VCs
  vcr_rr_pick #(.N(NUM_VC)) u_sa_pick (
    .clk        (clk),
    .rst        (rst),
    .req        (ready_vec),
    .advance    (sa_fire),
    .pick_valid (sa_req),
    .pick_idx   (sa_req_vc)
  );
  assign sa_req_port = vc_port[sa_req_vc];

  // switch traversal register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= DIR_LOCAL;
      out_vc    <= '0;
      out_kind  <= FL_BODY;
      out_data  <= '0;
    end else begin
      out_valid <= sa_fire;
      if (sa_fire) begin
        out_port <= vc_port[sa_req_vc];
        out_vc   <= vc_ovc[sa_req_vc];
        out_kind <= front[sa_req_vc][FW-1:DATA_W];
        out_data <= front[sa_req_vc][DATA_W-1:0];
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !va_req && !sa_req));

  // R3
  va_head_chk: assert property (@(posedge clk) disable iff (rst)
    va_req |-> (!empty_vec[va_req_vc] && (front[va_req_vc][FW-1:DATA_W] == FL_HEAD)));

  // R10
  st_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sa_fire |=> out_valid);

  // R10
  st_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sa_fire |=> !out_valid);

  // R8
  input_room_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !full_vec[in_vc]);

endmodule

// File: tb/vc_input_pipe_bench.sv
module vc_input_pipe_bench;
  localparam int NV  = 4;
  localparam int DEP = 8;
  localparam int DW  = 16;
  localparam int CW  = 3;
  localparam int MX  = 2;
  localparam int MY  = 2;
  localparam int VW  = $clog2(NV);
  localparam int QN  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [VW-1:0] in_vc = '0;
  logic [1:0] in_kind = '0;
  logic [DW-1:0] in_data = '0;
  logic va_req, sa_req, va_grant = 1'b0, sa_grant = 1'b0;
  logic [VW-1:0] va_req_vc, sa_req_vc, va_grant_ovc = '0, out_vc;
  logic [2:0] va_req_port, sa_req_port, out_port;
  logic out_valid;
  logic [1:0] out_kind;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  vc_input_pipe #(.NUM_VC(NV), .FIFO_DEPTH(DEP), .DATA_W(DW), .COORD_W(CW),
                  .MY_X(MX), .MY_Y(MY)) u_vc_input_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind),
    .in_data(in_data), .va_req(va_req), .va_req_vc(va_req_vc),
    .va_req_port(va_req_port), .va_grant(va_grant), .va_grant_ovc(va_grant_ovc),
    .sa_req(sa_req), .sa_req_vc(sa_req_vc), .sa_req_port(sa_req_port),
    .sa_grant(sa_grant), .out_valid(out_valid), .out_port(out_port),
    .out_vc(out_vc), .out_kind(out_kind), .out_data(out_data));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  logic [DW-1:0] qd [NV][QN];
  logic [1:0]    qk [NV][QN];
  logic [2:0]    qp [NV][QN];
  int qw [NV], qr [NV], rem [NV];
  logic [2:0] cur_port [NV];
  logic [VW-1:0] b_ovc [NV];
  bit act [NV];
  int last_rr = NV - 1;
  bit exp_v = 1'b0;
  logic [DW-1:0] exp_d;
  logic [1:0] exp_k;
  logic [2:0] exp_p;
  logic [VW-1:0] exp_o;
  int head_cyc = 0, tail_cyc = 0, va_seen = 0;

  task automatic chk(input bit ok, input string tag, input int actual, input int expect_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, actual, expect_v, cyc);
    end
  endtask

  function automatic logic [2:0] dor(input int dx, input int dy);
    if (dx > MX) return 3'd1;
    if (dx < MX) return 3'd2;
    if (dy > MY) return 3'd3;
    if (dy < MY) return 3'd4;
    return 3'd0;
  endfunction

  function automatic int rr_expect();
    for (int off = 1; off <= NV; off++) begin
      int c;
      c = (last_rr + off) % NV;
      if (act[c] && (qw[c] != qr[c])) return c;
    end
    return -1;
  endfunction

  task automatic tick(input bit snd, input int sv, input logic [1:0] sk,
                      input logic [DW-1:0] sd, input int va_pct, input int sa_pct);
    int e, v;
    @(negedge clk);
    cyc++;
    // R10 / R6: output of last cycle's grant
    if (exp_v) begin
      chk(out_valid == 1'b1, "R10 out_valid after grant", out_valid, 1);
      chk(out_data == exp_d, "R6 data order", out_data, exp_d);
      chk(out_kind == exp_k, "R6 kind", out_kind, exp_k);
      chk(out_port == exp_p, "R2 out_port", out_port, exp_p);
      chk(out_vc == exp_o, "R6 output vc", out_vc, exp_o);
      if (out_kind == 2'd1) head_cyc = cyc;
      if (out_kind == 2'd2) tail_cyc = cyc;
    end else begin
      chk(out_valid == 1'b0, "R5 no output without grant", out_valid, 0);
    end
    exp_v = 1'b0;
    // switch request and grant (R9, R7)
    e = rr_expect();
    chk(sa_req == (e >= 0), "R9 sa_req presence", sa_req, e >= 0);
    sa_grant = 1'b0;
    if (sa_req && e >= 0) begin
      v = int'(sa_req_vc);
      chk(v == e, "R9 rotation order", v, e);
      chk(sa_req_port == qp[v][qr[v] % QN], "R2 sa_req_port", sa_req_port, qp[v][qr[v] % QN]);
      if (($urandom % 100) < sa_pct) begin
        sa_grant = 1'b1;
        exp_v = 1'b1;
        exp_d = qd[v][qr[v] % QN];
        exp_k = qk[v][qr[v] % QN];
        exp_p = qp[v][qr[v] % QN];
        exp_o = b_ovc[v];
        qr[v]++;
        if (exp_k == 2'd2) act[v] = 1'b0;
        last_rr = v;
      end
    end
    // VC request and grant (R3)
    va_grant = 1'b0;
    va_grant_ovc = VW'($urandom % NV);
    if (va_req) begin
      v = int'(va_req_vc);
      va_seen++;
      chk(!act[v] && (qw[v] != qr[v]), "R7 va_req only for free vc", act[v], 0);
      chk(qk[v][qr[v] % QN] == 2'd1, "R3 va_req front is head", qk[v][qr[v] % QN], 1);
      chk(va_req_port == qp[v][qr[v] % QN], "R2 va_req_port", va_req_port, qp[v][qr[v] % QN]);
      if (($urandom % 100) < va_pct) begin
        va_grant = 1'b1;
        act[v] = 1'b1;
        b_ovc[v] = va_grant_ovc;
      end
    end
    // stimulus
    in_valid = snd;
    in_vc = VW'(sv);
    in_kind = sk;
    in_data = sd;
    if (snd) begin
      qd[sv][qw[sv] % QN] = sd;
      qk[sv][qw[sv] % QN] = sk;
      if (sk == 2'd1) cur_port[sv] = dor(int'(sd[CW-1:0]), int'(sd[2*CW-1:CW]));
      qp[sv][qw[sv] % QN] = cur_port[sv];
      qw[sv]++;
    end
  endtask

  task automatic idle(input int n, input int va_pct, input int sa_pct);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 2'd0, '0, va_pct, sa_pct);
  endtask

  function automatic logic [DW-1:0] head_data(input int dx, input int dy);
    logic [DW-1:0] d;
    d = DW'($urandom);
    d[CW-1:0] = CW'(dx);
    d[2*CW-1:CW] = CW'(dy);
    return d;
  endfunction

  task automatic send_pkt(input int v, input int dx, input int dy, input int len,
                          input int va_pct, input int sa_pct);
    for (int i = 0; i < len; i++) begin
      logic [1:0] k;
      k = (i == 0) ? 2'd1 : ((i == len - 1) ? 2'd2 : 2'd0);
      tick(1'b1, v, k, (i == 0) ? head_data(dx, dy) : DW'($urandom), va_pct, sa_pct);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (guard < 2000) begin
      bit busy;
      busy = 1'b0;
      for (int v = 0; v < NV; v++) if (qw[v] != qr[v]) busy = 1'b1;
      if (!busy && !exp_v) break;
      tick(1'b0, 0, 2'd0, '0, 100, 100);
      guard++;
    end
    idle(3, 100, 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0, s0, rv;
    rv = int'($urandom(32'd4242));
    for (int v = 0; v < NV; v++) begin
      qw[v] = 0; qr[v] = 0; rem[v] = 0; act[v] = 1'b0;
      cur_port[v] = '0; b_ovc[v] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet while reset is held
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(va_req == 1'b0, "R1 va_req in reset", va_req, 0);
    chk(sa_req == 1'b0, "R1 sa_req in reset", sa_req, 0);
    rst = 1'b0;
    idle(2, 100, 100);

    // R4 / R8: uncontended four-flit packet, bodies buffered behind the head
    send_pkt(0, 4, 2, 4, 100, 100);
    t0 = cyc - 3;
    idle(8, 100, 100);
    chk(head_cyc - t0 == 4, "R4 head latency", head_cyc - t0, 4);
    chk(tail_cyc - t0 == 7, "R4 tail latency", tail_cyc - t0, 7);

    // R5: head denied once at its switch request
    tick(1'b1, 1, 2'd1, head_data(2, 5), 100, 100);
    t0 = cyc;
    tick(1'b1, 1, 2'd0, DW'($urandom), 100, 100);
    tick(1'b1, 1, 2'd0, DW'($urandom), 100, 100);
    tick(1'b1, 1, 2'd2, DW'($urandom), 100, 0);
    idle(8, 100, 100);
    chk(head_cyc - t0 == 5, "R5 head slips one cycle", head_cyc - t0, 5);
    chk(tail_cyc - t0 == 8, "R5 tail slips one cycle", tail_cyc - t0, 8);

    // R7: VC 1 released; next packet must win a new VC before switching
    s0 = va_seen;
    send_pkt(1, 0, 2, 3, 0, 100);
    idle(6, 0, 100);
    chk(va_seen - s0 >= 6, "R7 freed vc asks again", va_seen - s0, 6);
    chk(qr[1] != qw[1], "R7 nothing switched before grant", qr[1], 0);
    drain();
    chk(qr[1] == qw[1], "R7 packet leaves after grant", qr[1], qw[1]);

    // R2: every direction, including local
    send_pkt(2, 2, 2, 2, 100, 100);
    send_pkt(2, 2, 0, 2, 100, 100);
    send_pkt(3, 7, 0, 2, 100, 100);
    send_pkt(3, 1, 6, 2, 100, 100);
    send_pkt(2, 2, 7, 2, 100, 100);
    drain();

    // R9 / R6 / R8: random mixed traffic over all VCs
    for (int i = 0; i < 4000; i++) begin
      int v;
      v = int'($urandom % NV);
      if ((qw[v] - qr[v]) < DEP && ($urandom % 100) < 70) begin
        logic [1:0] k;
        logic [DW-1:0] d;
        if (rem[v] == 0) begin
          k = 2'd1;
          d = head_data(int'($urandom % 8), int'($urandom % 8));
          rem[v] = 1 + int'($urandom % 4);
        end else begin
          k = (rem[v] == 1) ? 2'd2 : 2'd0;
          d = DW'($urandom);
          rem[v]--;
        end
        tick(1'b1, v, k, d, 60, 70);
      end else begin
        tick(1'b0, 0, 2'd0, '0, 60, 70);
      end
    end
    drain();
    for (int v = 0; v < NV; v++)
      chk(qr[v] == qw[v], "R8 no flit lost", qr[v], qw[v]);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule